// File: doc/BRIEF.md
# Two-Bit Interrupt Source Gate

This block keeps a two-bit state for each interrupt source and decides, event by event, whether the source may send a notification to the routing stage. Bit P records that a notification has left and that the source is waiting for its end-of-interrupt. Bit Q records that one more event arrived in the meantime. The combination with only Q set marks a source that is switched off. Because of these two bits, each source has at most one notification in flight and remembers at most one extra event. Any further events are merged.

Message-style sources fire through a trigger port that carries a source index. Level-style sources are the indices at or above `LEVEL_BASE`, and they fire from their own input line whenever the line is high. Software can read each source's state through a small management port. The same port can also swap in a new two-bit value atomically, and writing the off value disables the source. End-of-interrupt requests arrive on a separate port. Outgoing notifications carry the source number and use a valid/ready handshake. When the output stalls, the obligation stays in a per-source flag, so nothing is lost.

Top module: `pq_source_gate`

## Requirements
- R1: After reset every source is in state 00 (ready), `notify_valid` is low and `mg_rvalid` is low.
- R2: A message trigger moves a source in 00 to 10 and issues one notify. In 10 it moves to 11 with no notify. In 11 or 01 the state stays unchanged and no notify is issued. The state is encoded {P,Q}: 00 ready, 10 sent, 11 queued, 01 off.
- R3: An end-of-interrupt moves a source in 10 to 00. It moves a source in 11 to 10 and issues a new notify. In 00 and 01 it has no effect.
- R4: A level source (index ≥ `LEVEL_BASE`) triggers whenever its line is high, but only when it is in state 00. A held line never moves it to 11, and the trigger port has no effect on it. An end-of-interrupt while the line is still high leaves it in 10 and issues a new notify.
- R5: A management access with `mg_req` high returns, one cycle later, `mg_rvalid` high and `mg_rdata` equal to the state the addressed source held before that cycle's updates. `mg_rvalid` is low in the cycle after a cycle without `mg_req`.
- R6: A swap (`mg_swap` high) stores `mg_wval` into the addressed source, and that value overrides any trigger or end-of-interrupt on the same source in the same cycle. A notify posted by that trigger or end-of-interrupt is still delivered. The swap itself never issues a notify.
- R7: A source in state 01 stays in 01 under triggers, line levels and end-of-interrupts until a swap writes another value.
- R8: When a trigger and an end-of-interrupt hit one source in the same cycle, the end-of-interrupt is applied first and the trigger is applied to the result.
- R9: While `notify_valid` is high and `notify_ready` is low, `notify_valid` stays high and `notify_idx` stays stable. Every posted notify is eventually delivered. A source never receives more notifies than it posted. Posts made while an earlier one from the same source still waits unpresented are merged into it.
- R10: When the output frees up, the waiting source with the lowest index is presented next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_valid | input | 1 | Message trigger strobe |
| trig_idx | input | IDX_W | Source index of the trigger |
| lvl_line | input | NUM_SRC | Per-source level lines (used by level sources only) |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_idx | input | IDX_W | Source index of the end-of-interrupt |
| mg_req | input | 1 | Management access strobe |
| mg_swap | input | 1 | Access also writes `mg_wval` |
| mg_idx | input | IDX_W | Source addressed by the access |
| mg_wval | input | 2 | New {P,Q} value for a swap |
| mg_rvalid | output | 1 | Read data valid, one cycle after `mg_req` |
| mg_rdata | output | 2 | {P,Q} state before the access |
| notify_valid | output | 1 | Notification available |
| notify_ready | input | 1 | Downstream accepts the notification |
| notify_idx | output | IDX_W | Source number of the notification |

## Verification
The assertions check the following on every cycle: the notify output stays stable under backpressure, a read answers exactly one cycle after each access, a swap always lands in the addressed state, an off source never leaves 01 without a swap, and no source jumps from ready straight to queued. Only the bench scenarios can show the rest. These are the exact transition tables and notify counts, the level re-trigger at end-of-interrupt, the same-cycle ordering of end-of-interrupt before trigger, the rule that a swap overrides same-cycle events while their notify survives, and the lowest-index presentation order. A random run then checks, against a model of the requirements, that no notify is lost or invented.

// File: rtl/pq_gate_pkg.sv
`timescale 1ns/1ps
package pq_gate_pkg;
  // {P,Q} encoding of a source state
  typedef enum logic [1:0] {
    PQ_READY  = 2'b00,
    PQ_OFF    = 2'b01,
    PQ_SENT   = 2'b10,
    PQ_QUEUED = 2'b11
  } pq_state_e;
endpackage

// File: rtl/pq_gate_rst_sync.sv
`timescale 1ns/1ps
module pq_gate_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pq_gate_cell.sv
`timescale 1ns/1ps
module pq_gate_cell
  import pq_gate_pkg::*;
#(
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       msg_trig_i,
  input  logic       line_i,
  input  logic       eoi_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_val_i,
  output logic [1:0] state_o,
  output logic       post_o
);
  pq_state_e st_q, st_d, st_mid;
  logic      trig_eff, st_en, post_eoi, post_trig;

  // level sources fire from their line, message sources from the port
  assign trig_eff = IS_LEVEL ? line_i : msg_trig_i;

  // stage 1: end-of-interrupt
  always_comb begin
    st_mid   = st_q;
    post_eoi = 1'b0;
    if (eoi_i) begin
      unique case (st_q)
        PQ_SENT:   st_mid = PQ_READY;
        PQ_QUEUED: begin
          st_mid   = PQ_SENT;
          post_eoi = 1'b1;
        end
        default:   st_mid = st_q;
      endcase
    end
  end

  // stage 2: trigger on the result, then the software override
  always_comb begin
    st_d      = st_mid;
    post_trig = 1'b0;
    if (trig_eff) begin
      if (st_mid == PQ_READY) begin
        st_d      = PQ_SENT;
        post_trig = 1'b1;
      end else if (st_mid == PQ_SENT && !IS_LEVEL) begin
        st_d = PQ_QUEUED;
      end
    end
    if (wr_en_i) st_d = pq_state_e'(wr_val_i);
  end

  assign st_en = eoi_i | trig_eff | wr_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= PQ_READY;
    else if (st_en) st_q <= st_d;
  end

  assign state_o = st_q;
  assign post_o  = post_eoi | post_trig;
endmodule

// File: rtl/pq_gate_notify.sv
`timescale 1ns/1ps
module pq_gate_notify #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] post_vec,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_SRC-1:0] req_q, req_d, clr_vec;
  logic               req_en;
  logic               out_valid_q, out_valid_d;
  logic [IDX_W-1:0]   out_idx_q, out_idx_d;
  logic               take, found;
  logic [IDX_W-1:0]   pick;

  // output register may load when empty or being accepted
  assign take = !out_valid_q || ready_i;

  // lowest waiting index
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_q[i]) begin
        found = 1'b1;
        pick  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      clr_vec[i] = take && found && (pick == IDX_W'(i));
    end
    // a new post wins over the clear of the same source
    req_d  = (req_q & ~clr_vec) | post_vec;
    req_en = (|post_vec) | (take && found);
  end

  always_comb begin
    out_valid_d = found;
    out_idx_d   = found ? pick : out_idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= '0;
    else if (req_en) req_q <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_idx_q   <= '0;
    end else if (take) begin
      out_valid_q <= out_valid_d;
      out_idx_q   <= out_idx_d;
    end
  end

  assign valid_o = out_valid_q;
  assign idx_o   = out_idx_q;
endmodule

// File: rtl/pq_gate_mgmt.sv
`timescale 1ns/1ps
module pq_gate_mgmt #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [NUM_SRC-1:0][1:0] st_vec,
  output logic                   rvalid_o,
  output logic [1:0]             rdata_o
);
  logic [1:0] rd_mux;
  logic [1:0] rdata_q;
  logic       rvalid_q;

  always_comb begin
    rd_mux = 2'b00;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (idx_i == IDX_W'(i)) rd_mux = st_vec[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= 2'b00;
    else if (req_i) rdata_q <= rd_mux;
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/pq_source_gate.sv
`timescale 1ns/1ps
module pq_source_gate #(
  parameter int NUM_SRC    = 16,
  parameter int LEVEL_BASE = 12,
  localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_valid,
  input  logic [IDX_W-1:0]   trig_idx,
  input  logic [NUM_SRC-1:0] lvl_line,
  input  logic               eoi_valid,
  input  logic [IDX_W-1:0]   eoi_idx,
  input  logic               mg_req,
  input  logic               mg_swap,
  input  logic [IDX_W-1:0]   mg_idx,
  input  logic [1:0]         mg_wval,
  output logic               mg_rvalid,
  output logic [1:0]         mg_rdata,
  output logic               notify_valid,
  input  logic               notify_ready,
  output logic [IDX_W-1:0]   notify_idx
);
  logic                    rst_sync_n;
  logic [NUM_SRC-1:0][1:0] st_vec;
  logic [NUM_SRC-1:0]      post_vec;

  pq_gate_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam bit LVL = (g >= LEVEL_BASE);
    logic msg_hit, eoi_hit, wr_hit;

    assign msg_hit = trig_valid && (trig_idx == IDX_W'(g));
    assign eoi_hit = eoi_valid  && (eoi_idx  == IDX_W'(g));
    assign wr_hit  = mg_req && mg_swap && (mg_idx == IDX_W'(g));

    pq_gate_cell #(.IS_LEVEL(LVL)) u_cell (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .msg_trig_i (msg_hit),
      .line_i     (lvl_line[g]),
      .eoi_i      (eoi_hit),
      .wr_en_i    (wr_hit),
      .wr_val_i   (mg_wval),
      .state_o    (st_vec[g]),
      .post_o     (post_vec[g])
    );
  end

  pq_gate_mgmt #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_mgmt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_i    (mg_req),
    .idx_i    (mg_idx),
    .st_vec   (st_vec),
    .rvalid_o (mg_rvalid),
    .rdata_o  (mg_rdata)
  );

  pq_gate_notify #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_notify (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .post_vec (post_vec),
    .ready_i  (notify_ready),
    .valid_o  (notify_valid),
    .idx_o    (notify_idx)
  );
endmodule

// File: rtl/pq_source_gate_chk.sv
`timescale 1ns/1ps
module pq_source_gate_chk #(
  parameter int NUM_SRC = 16,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mg_req,
  input logic                    mg_swap,
  input logic [IDX_W-1:0]        mg_idx,
  input logic [1:0]              mg_wval,
  input logic                    mg_rvalid,
  input logic                    notify_valid,
  input logic                    notify_ready,
  input logic [IDX_W-1:0]        notify_idx,
  input logic [NUM_SRC-1:0][1:0] st_vec
);
  AST_NOTIFY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid && !notify_ready |=> notify_valid && $stable(notify_idx)); // R9

  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    mg_req |=> mg_rvalid); // R5

  AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mg_req |=> !mg_rvalid); // R5

  AST_SWAP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    mg_req && mg_swap |=> st_vec[$past(mg_idx)] == $past(mg_wval)); // R6

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    logic wr_g;
    assign wr_g = mg_req && mg_swap && (mg_idx == IDX_W'(g));

    AST_OFF_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      st_vec[g] == 2'b01 && !wr_g |=> st_vec[g] == 2'b01); // R7

    AST_NO_SKIP_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
      st_vec[g] == 2'b00 && !wr_g |=> st_vec[g] != 2'b11); // R2
  end
endmodule

bind pq_source_gate pq_source_gate_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .mg_req       (mg_req),
  .mg_swap      (mg_swap),
  .mg_idx       (mg_idx),
  .mg_wval      (mg_wval),
  .mg_rvalid    (mg_rvalid),
  .notify_valid (notify_valid),
  .notify_ready (notify_ready),
  .notify_idx   (notify_idx),
  .st_vec       (st_vec)
);

// File: tb/pq_source_gate_tb_top.sv
`timescale 1ns/1ps
module pq_source_gate_tb_top;
  localparam int N  = 16;
  localparam int IW = 4;
  localparam int LB = 12;

  logic          clk;
  logic          rst_n;
  logic          trig_valid;
  logic [IW-1:0] trig_idx;
  logic [N-1:0]  lvl_line;
  logic          eoi_valid;
  logic [IW-1:0] eoi_idx;
  logic          mg_req;
  logic          mg_swap;
  logic [IW-1:0] mg_idx;
  logic [1:0]    mg_wval;
  logic          mg_rvalid;
  logic [1:0]    mg_rdata;
  logic          notify_valid;
  logic          notify_ready;
  logic [IW-1:0] notify_idx;

  pq_source_gate #(.NUM_SRC(N), .LEVEL_BASE(LB)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_idx(trig_idx),
    .lvl_line(lvl_line), .eoi_valid(eoi_valid), .eoi_idx(eoi_idx),
    .mg_req(mg_req), .mg_swap(mg_swap), .mg_idx(mg_idx), .mg_wval(mg_wval),
    .mg_rvalid(mg_rvalid), .mg_rdata(mg_rdata), .notify_valid(notify_valid),
    .notify_ready(notify_ready), .notify_idx(notify_idx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;
  logic [1:0] mst [N];
  int         posts [N];
  int         got [N];
  int         dlog [8];
  int         log_n = 0;
  string      cur_tag = "R1";

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock cycle: inputs are already driven after a negedge
  task automatic cyc();
    bit         rd_pend;
    logic [1:0] rd_exp;
    rd_exp = 2'b00;
    if (notify_valid && notify_ready) begin
      got[notify_idx]++;
      if (log_n < 8) begin
        dlog[log_n] = int'(notify_idx);
        log_n++;
      end
    end
    rd_pend = mg_req;
    if (mg_req) rd_exp = mst[mg_idx];
    for (int i = 0; i < N; i++) begin
      logic [1:0] s;
      bit lvl, t, e;
      s   = mst[i];
      lvl = (i >= LB);
      t   = lvl ? lvl_line[i] : (trig_valid && trig_idx == IW'(i));
      e   = eoi_valid && eoi_idx == IW'(i);
      if (e) begin
        if (s == 2'b10) s = 2'b00;
        else if (s == 2'b11) begin s = 2'b10; posts[i]++; end
      end
      if (t) begin
        if (s == 2'b00) begin s = 2'b10; posts[i]++; end
        else if (s == 2'b10 && !lvl) s = 2'b11;
      end
      if (mg_req && mg_swap && mg_idx == IW'(i)) s = mg_wval;
      mst[i] = s;
    end
    @(negedge clk);
    if (rd_pend) begin
      check(mg_rvalid == 1'b1, {cur_tag, " R5 rvalid"}, int'(mg_rvalid), 1);
      check(mg_rdata == rd_exp, {cur_tag, " R5 rdata"}, int'(mg_rdata), int'(rd_exp));
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic pulse_trig(int i);
    trig_valid = 1'b1; trig_idx = IW'(i);
    cyc();
    trig_valid = 1'b0;
  endtask

  task automatic pulse_eoi(int i);
    eoi_valid = 1'b1; eoi_idx = IW'(i);
    cyc();
    eoi_valid = 1'b0;
  endtask

  task automatic access(int i, bit swp, logic [1:0] wv, output logic [1:0] v);
    mg_req = 1'b1; mg_swap = swp; mg_idx = IW'(i); mg_wval = wv;
    cyc();
    mg_req = 1'b0; mg_swap = 1'b0;
    v = mg_rdata;
  endtask

  task automatic expect_state(int i, logic [1:0] e, string tag);
    logic [1:0] v;
    access(i, 1'b0, 2'b00, v);
    check(v == e, tag, int'(v), int'(e));
  endtask

  task automatic counts_exact(string tag);
    for (int i = 0; i < N; i++) check(got[i] == posts[i], tag, got[i], posts[i]);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [1:0] v;
    trig_valid = 0; trig_idx = '0; lvl_line = '0; eoi_valid = 0; eoi_idx = '0;
    mg_req = 0; mg_swap = 0; mg_idx = '0; mg_wval = '0; notify_ready = 1'b1;
    for (int i = 0; i < N; i++) begin mst[i] = 2'b00; posts[i] = 0; got[i] = 0; end
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    cur_tag = "R1";
    check(notify_valid == 1'b0, "R1 notify_valid", int'(notify_valid), 0);
    check(mg_rvalid == 1'b0, "R1 rvalid", int'(mg_rvalid), 0);
    for (int i = 0; i < N; i++) expect_state(i, 2'b00, "R1 state");

    // R2 / R3: message source transitions
    cur_tag = "R2";
    pulse_trig(3); idle(4);
    expect_state(3, 2'b10, "R2 ready->sent");
    check(got[3] == 1, "R2 notify on first trigger", got[3], 1);
    pulse_trig(3); idle(4);
    expect_state(3, 2'b11, "R2 sent->queued");
    check(got[3] == 1, "R2 no notify when queued", got[3], 1);
    pulse_trig(3); idle(2);
    expect_state(3, 2'b11, "R2 queued holds");
    cur_tag = "R3";
    pulse_eoi(3); idle(4);
    expect_state(3, 2'b10, "R3 queued->sent");
    check(got[3] == 2, "R3 fresh notify", got[3], 2);
    pulse_eoi(3); idle(2);
    expect_state(3, 2'b00, "R3 sent->ready");
    pulse_eoi(3); idle(2);
    expect_state(3, 2'b00, "R3 eoi in ready ignored");

    // R6 / R7: swap and off state
    cur_tag = "R7";
    access(5, 1'b1, 2'b01, v);
    check(v == 2'b00, "R6 swap returns old", int'(v), 0);
    pulse_trig(5); pulse_eoi(5); idle(4);
    expect_state(5, 2'b01, "R7 off holds");
    check(got[5] == 0, "R7 no notify when off", got[5], 0);
    access(13, 1'b1, 2'b01, v);
    lvl_line[13] = 1'b1; idle(4);
    expect_state(13, 2'b01, "R7 level off holds");
    check(got[13] == 0, "R7 level off no notify", got[13], 0);
    lvl_line[13] = 1'b0;
    cur_tag = "R6";
    access(2, 1'b1, 2'b11, v); idle(4);
    check(got[2] == 0, "R6 swap posts nothing", got[2], 0);
    pulse_eoi(2); idle(4);
    expect_state(2, 2'b10, "R6 swapped queued then eoi");
    check(got[2] == 1, "R6 eoi after swap notifies", got[2], 1);
    trig_valid = 1'b1; trig_idx = IW'(8);
    mg_req = 1'b1; mg_swap = 1'b1; mg_idx = IW'(8); mg_wval = 2'b00;
    cyc();
    trig_valid = 1'b0; mg_req = 1'b0; mg_swap = 1'b0;
    idx_wait: idle(4);
    expect_state(8, 2'b00, "R6 swap overrides trigger");
    check(got[8] == 1, "R6 trigger notify survives", got[8], 1);

    // R4: level sources
    cur_tag = "R4";
    pulse_trig(12); idle(2);
    expect_state(12, 2'b00, "R4 trigger port ignored");
    lvl_line[12] = 1'b1; idle(6);
    expect_state(12, 2'b10, "R4 held line stays sent");
    check(got[12] == 1, "R4 one notify", got[12], 1);
    pulse_eoi(12); idle(4);
    expect_state(12, 2'b10, "R4 eoi retriggers");
    check(got[12] == 2, "R4 retrigger notify", got[12], 2);
    lvl_line[12] = 1'b0;
    pulse_eoi(12); idle(2);
    expect_state(12, 2'b00, "R4 eoi line low");

    // R8: same-cycle trigger and eoi
    cur_tag = "R8";
    pulse_trig(7); idle(4);
    trig_valid = 1'b1; trig_idx = IW'(7); eoi_valid = 1'b1; eoi_idx = IW'(7);
    cyc();
    trig_valid = 1'b0; eoi_valid = 1'b0; idx_wait2: idle(4);
    expect_state(7, 2'b10, "R8 sent: eoi then trigger");
    check(got[7] == 2, "R8 sent notify", got[7], 2);
    pulse_trig(7); idle(2);
    trig_valid = 1'b1; trig_idx = IW'(7); eoi_valid = 1'b1; eoi_idx = IW'(7);
    cyc();
    trig_valid = 1'b0; eoi_valid = 1'b0; idle(4);
    expect_state(7, 2'b11, "R8 queued: eoi then trigger");
    check(got[7] == 3, "R8 queued notify", got[7], 3);

    // R9 / R10: backpressure and order
    cur_tag = "R9";
    notify_ready = 1'b0;
    pulse_trig(9); idle(3);
    check(notify_valid == 1'b1, "R9 valid under stall", int'(notify_valid), 1);
    check(notify_idx == 4'd9, "R9 idx under stall", int'(notify_idx), 9);
    pulse_trig(3 + 1 + 6); // source 10
    pulse_trig(1); idle(3);
    check(notify_valid == 1'b1, "R9 valid still held", int'(notify_valid), 1);
    check(notify_idx == 4'd9, "R9 idx stable", int'(notify_idx), 9);
    notify_ready = 1'b1; log_n = 0; idle(6);
    check(log_n == 3, "R10 delivered count", log_n, 3);
    check(dlog[0] == 9, "R10 first", dlog[0], 9);
    check(dlog[1] == 1, "R10 lowest next", dlog[1], 1);
    check(dlog[2] == 10, "R10 then higher", dlog[2], 10);
    counts_exact("R9 exact counts");

    // random phase
    cur_tag = "R9 random";
    void'($urandom(32'h5EED1234));
    for (int c = 0; c < 4000; c++) begin
      trig_valid   = ($urandom % 4) == 0;
      trig_idx     = IW'($urandom % N);
      eoi_valid    = ($urandom % 4) == 0;
      eoi_idx      = IW'($urandom % N);
      mg_req       = ($urandom % 8) == 0;
      mg_swap      = ($urandom % 6) == 0;
      mg_idx       = IW'($urandom % N);
      mg_wval      = 2'($urandom % 4);
      notify_ready = ($urandom % 10) < 7;
      if (($urandom % 16) == 0) begin
        int li;
        li = LB + int'($urandom % (N - LB));
        lvl_line[li] = ~lvl_line[li];
      end
      cyc();
    end
    trig_valid = 0; eoi_valid = 0; mg_req = 0; mg_swap = 0;
    lvl_line = '0; notify_ready = 1'b1;
    idle(40);
    for (int i = 0; i < N; i++) begin
      if (posts[i] > 0) begin
        check(got[i] >= 1, "R9 no lost notify", got[i], 1);
        check(got[i] <= posts[i], "R9 no extra notify", got[i], posts[i]);
      end else begin
        check(got[i] == 0, "R9 no invented notify", got[i], 0);
      end
    end
    cur_tag = "R5 final";
    for (int i = 0; i < N; i++) expect_state(i, mst[i], "R5 final state");
    check(notify_valid == 1'b0, "R9 drained", int'(notify_valid), 0);
    finish_run();
  end
endmodule